// File: doc/BRIEF.md
# FIFO Level, Interrupt and DMA Request Unit

This block holds the transmit and receive word queues that sit between a bus slave port and a serial shift engine. The bus side writes words into the transmit queue and reads words from the receive queue. The serial engine drains the transmit queue and fills the receive queue. Around the two queues the block keeps level counts and a five-bit status word. It keeps four programmable watermarks: two for interrupts and two for DMA. It also holds an interrupt mask, a DMA enable pair, and five raw interrupt sources. The block drives one interrupt line and one DMA request line for each direction.

Every watermark register accepts only values below the queue depth, and a write of the depth or more leaves it unchanged. Software can therefore find the depth by writing increasing values and reading each one back. The block has no address decoding. A single write strobe with a 3-bit register select stands in for the bus decode, and all register contents are visible on output ports.

Top module: `fifo_irq_dma_ctrl`

## Requirements
- R1: After reset both levels are 0, status is 0x0C, raw interrupts are 0x01, and all watermarks, the mask, the DMA enables, the interrupt line and both DMA requests are 0.
- R2: Each queue returns words in the order they were accepted, and its level port counts the words held. The receive level returns to 0 once every word has been read.
- R3: Status bit positions are: bit 0 busy, bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full. Full means the level equals the depth.
- R4: A transmit push while the level equals the depth drops the word, keeps the level, and sets raw bit 1 (transmit overflow).
- R5: A receive pop while the receive queue is empty returns 0 and sets raw bit 2 (receive underflow). A receive push while that queue is full drops the word and sets raw bit 3 (receive overflow). An engine pop of an empty transmit queue returns 0 and sets no flag.
- R6: Watermark registers take a written value only when it is below the depth. A write of the depth or more leaves the old value in place.
- R7: Raw bit 0 is 1 while the transmit level is at or below the transmit interrupt watermark. Raw bit 4 is 1 while the receive level is strictly above the receive interrupt watermark.
- R8: The masked word is the raw word ANDed with the mask (mask bit i enables raw bit i). The interrupt line is the OR of the masked word.
- R9: Raw bits 1 to 3 stay set until cleared. The clear write uses bit 0 to clear all, bit 1 for receive underflow, bit 2 for receive overflow and bit 3 for transmit overflow. A set in the same cycle as a clear wins.
- R10: DMA enable bit 0 gates the receive request and bit 1 gates the transmit request. The transmit request is high while the transmit level is at or below the transmit DMA watermark. The receive request is high while the receive level is above the receive DMA watermark.
- R11: The busy status bit is 1 while the engine reports busy or the transmit queue holds data.
- R12: The register select codes are: 0 transmit interrupt watermark, 1 receive interrupt watermark, 2 transmit DMA watermark, 3 receive DMA watermark, 4 mask, 5 DMA enables, 6 clear. A write with code 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_push_i | input | 1 | Bus writes a word into the transmit queue |
| tx_wdata_i | input | DW | Transmit word from the bus |
| tx_pop_i | input | 1 | Engine takes the head transmit word |
| tx_rdata_o | output | DW | Head transmit word, 0 when empty |
| rx_push_i | input | 1 | Engine writes a received word |
| rx_wdata_i | input | DW | Received word from the engine |
| rx_pop_i | input | 1 | Bus reads the head receive word |
| rx_rdata_o | output | DW | Head receive word, 0 when empty |
| engine_busy_i | input | 1 | Serial engine is shifting |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select code |
| cfg_wdata_i | input | CW | Register write data |
| tx_level_o | output | LW | Transmit queue level |
| rx_level_o | output | LW | Receive queue level |
| status_o | output | 5 | Status word |
| raw_irq_o | output | 5 | Raw interrupt sources |
| masked_irq_o | output | 5 | Raw sources after the mask |
| irq_o | output | 1 | Interrupt line |
| tx_irq_thr_o | output | TW | Transmit interrupt watermark |
| rx_irq_thr_o | output | TW | Receive interrupt watermark |
| tx_dma_lvl_o | output | TW | Transmit DMA watermark |
| rx_dma_lvl_o | output | TW | Receive DMA watermark |
| irq_mask_o | output | 5 | Interrupt mask |
| dma_en_o | output | 2 | DMA enables |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |

## Verification
A wrong level count appears on the level and status ports in the cycle after the push or pop that caused it. It also moves the watermark-driven raw bits and DMA requests in that same cycle. A read pointer that slips shows up on the very next read as a wrong word, since the bench compares every popped word against the order in which words were pushed. A sticky flag that is lost or cleared by the wrong clear bit appears on the raw word right after the clear write. A watermark register that accepts an out-of-range value appears on its readback one cycle after the write.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  typedef enum logic [2:0] {
    SEL_TX_IRQ_THR = 3'd0,
    SEL_RX_IRQ_THR = 3'd1,
    SEL_TX_DMA_LVL = 3'd2,
    SEL_RX_DMA_LVL = 3'd3,
    SEL_IRQ_MASK   = 3'd4,
    SEL_DMA_EN     = 3'd5,
    SEL_IRQ_CLR    = 3'd6,
    SEL_NONE       = 3'd7
  } cfg_sel_e;

  localparam int NUM_THR = 4;
  localparam int NUM_IRQ = 5;
  localparam int NUM_ST  = 5;
  localparam int NUM_CLR = 4;

  localparam int ST_BUSY     = 0;
  localparam int ST_TX_FULL  = 1;
  localparam int ST_TX_EMPTY = 2;
  localparam int ST_RX_EMPTY = 3;
  localparam int ST_RX_FULL  = 4;

  localparam int IRQ_TX_EMPTY = 0;
  localparam int IRQ_TX_OVF   = 1;
  localparam int IRQ_RX_UDF   = 2;
  localparam int IRQ_RX_OVF   = 3;
  localparam int IRQ_RX_FULL  = 4;

  localparam int CLR_ALL    = 0;
  localparam int CLR_RX_UDF = 1;
  localparam int CLR_RX_OVF = 2;
  localparam int CLR_TX_OVF = 3;

  localparam int DMA_RX_EN = 0;
  localparam int DMA_TX_EN = 1;
endpackage

// File: rtl/fifo_irq_fifo.sv
module fifo_irq_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_drop_o,
  output logic          pop_miss_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q;
  logic          push_ok, pop_ok;

  assign full_o      = (level_q == LW'(DEPTH));
  assign empty_o     = (level_q == '0);
  assign push_ok     = push_i && !full_o;
  assign pop_ok      = pop_i && !empty_o;
  assign push_drop_o = push_i && full_o;
  assign pop_miss_o  = pop_i && empty_o;
  assign level_o     = level_q;
  assign rdata_o     = empty_o ? '0 : mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push_ok) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  a_r2_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));

  a_r4_drop_keeps_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (level_o == $past(level_o)));

  a_r5_miss_stays_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);

  a_r2_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !pop_i) |=> (level_o == $past(level_o) + 1'b1));
endmodule

// File: rtl/fifo_irq_cfg.sv
module fifo_irq_cfg
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 8,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [2:0]                 sel_i,
  input  logic [CW-1:0]              wdata_i,
  output logic [NUM_THR-1:0][TW-1:0] thr_o,
  output logic [NUM_IRQ-1:0]         mask_o,
  output logic [1:0]                 dma_en_o,
  output logic [NUM_CLR-1:0]         clr_o
);
  cfg_sel_e sel;
  logic     in_range;

  assign sel      = cfg_sel_e'(sel_i);
  assign in_range = (wdata_i < CW'(DEPTH));

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    logic [TW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     q <= '0;
      else if (we_i && sel_i == 3'(g) && in_range)     q <= wdata_i[TW-1:0];
    end
    assign thr_o[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o   <= '0;
      dma_en_o <= '0;
    end else if (we_i) begin
      if (sel == SEL_IRQ_MASK) mask_o   <= wdata_i[NUM_IRQ-1:0];
      if (sel == SEL_DMA_EN)   dma_en_o <= wdata_i[1:0];
    end
  end

  assign clr_o = (we_i && sel == SEL_IRQ_CLR) ? wdata_i[NUM_CLR-1:0] : '0;

  a_r6_reject_big: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 3'(SEL_TX_IRQ_THR) && wdata_i >= CW'(DEPTH)) |=> $stable(thr_o[0]));

  a_r6_accept_small: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 3'(SEL_RX_IRQ_THR) && wdata_i < CW'(DEPTH))
      |=> (CW'(thr_o[1]) == $past(wdata_i)));

  a_r12_unused_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 3'(SEL_NONE)) |=> ($stable(thr_o) && $stable(mask_o) && $stable(dma_en_o)));
endmodule

// File: rtl/fifo_irq_flags.sv
module fifo_irq_flags
  import fifo_irq_pkg::*;
#(
  parameter int LW = 4,
  parameter int TW = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LW-1:0]      tx_level_i,
  input  logic [LW-1:0]      rx_level_i,
  input  logic [TW-1:0]      tx_thr_i,
  input  logic [TW-1:0]      rx_thr_i,
  input  logic               tx_ovf_set_i,
  input  logic               rx_udf_set_i,
  input  logic               rx_ovf_set_i,
  input  logic [NUM_CLR-1:0] clr_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  output logic [NUM_IRQ-1:0] raw_o,
  output logic [NUM_IRQ-1:0] masked_o,
  output logic               irq_o
);
  localparam int NUM_STICKY = 3;

  logic [NUM_STICKY-1:0] set_v, clr_v, flag_q;

  // sticky order: tx overflow, rx underflow, rx overflow
  assign set_v = {rx_ovf_set_i, rx_udf_set_i, tx_ovf_set_i};
  assign clr_v = {clr_i[CLR_RX_OVF], clr_i[CLR_RX_UDF], clr_i[CLR_TX_OVF]}
               | {NUM_STICKY{clr_i[CLR_ALL]}};

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= set_v[i] | (flag_q[i] & ~clr_v[i]);
    end

    a_r9_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr_v[i]) |=> flag_q[i]);

    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_v[i] |=> flag_q[i]);
  end

  always_comb begin
    raw_o               = '0;
    raw_o[IRQ_TX_EMPTY] = (tx_level_i <= LW'(tx_thr_i));
    raw_o[IRQ_TX_OVF]   = flag_q[0];
    raw_o[IRQ_RX_UDF]   = flag_q[1];
    raw_o[IRQ_RX_OVF]   = flag_q[2];
    raw_o[IRQ_RX_FULL]  = (rx_level_i > LW'(rx_thr_i));
  end

  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;

  a_r8_quiet_when_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o);

  a_r9_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[CLR_ALL] && set_v == '0) |=> (flag_q == '0));
endmodule

// File: rtl/fifo_irq_dma_ctrl.sv
module fifo_irq_dma_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int CW    = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_wdata_i,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_rdata_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_wdata_i,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_rdata_o,
  input  logic          engine_busy_i,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [CW-1:0] cfg_wdata_i,
  output logic [LW-1:0] tx_level_o,
  output logic [LW-1:0] rx_level_o,
  output logic [4:0]    status_o,
  output logic [4:0]    raw_irq_o,
  output logic [4:0]    masked_irq_o,
  output logic          irq_o,
  output logic [TW-1:0] tx_irq_thr_o,
  output logic [TW-1:0] rx_irq_thr_o,
  output logic [TW-1:0] tx_dma_lvl_o,
  output logic [TW-1:0] rx_dma_lvl_o,
  output logic [4:0]    irq_mask_o,
  output logic [1:0]    dma_en_o,
  output logic          tx_dma_req_o,
  output logic          rx_dma_req_o
);
  logic tx_full, tx_empty, tx_drop, tx_miss;
  logic rx_full, rx_empty, rx_drop, rx_miss;
  logic [NUM_THR-1:0][TW-1:0] thr;
  logic [NUM_CLR-1:0]         clr;

  fifo_irq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push_i), .wdata_i(tx_wdata_i), .pop_i(tx_pop_i), .rdata_o(tx_rdata_o),
    .level_o(tx_level_o), .full_o(tx_full), .empty_o(tx_empty),
    .push_drop_o(tx_drop), .pop_miss_o(tx_miss)
  );

  fifo_irq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push_i), .wdata_i(rx_wdata_i), .pop_i(rx_pop_i), .rdata_o(rx_rdata_o),
    .level_o(rx_level_o), .full_o(rx_full), .empty_o(rx_empty),
    .push_drop_o(rx_drop), .pop_miss_o(rx_miss)
  );

  fifo_irq_cfg #(.DEPTH(DEPTH), .CW(CW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .thr_o(thr), .mask_o(irq_mask_o), .dma_en_o(dma_en_o), .clr_o(clr)
  );

  assign tx_irq_thr_o = thr[SEL_TX_IRQ_THR];
  assign rx_irq_thr_o = thr[SEL_RX_IRQ_THR];
  assign tx_dma_lvl_o = thr[SEL_TX_DMA_LVL];
  assign rx_dma_lvl_o = thr[SEL_RX_DMA_LVL];

  fifo_irq_flags #(.LW(LW), .TW(TW)) u_flags (
    .clk_i, .rst_ni,
    .tx_level_i(tx_level_o), .rx_level_i(rx_level_o),
    .tx_thr_i(tx_irq_thr_o), .rx_thr_i(rx_irq_thr_o),
    .tx_ovf_set_i(tx_drop), .rx_udf_set_i(rx_miss), .rx_ovf_set_i(rx_drop),
    .clr_i(clr), .mask_i(irq_mask_o),
    .raw_o(raw_irq_o), .masked_o(masked_irq_o), .irq_o(irq_o)
  );

  // an engine-side miss on the tx queue is harmless: it reads zero, no flag
  logic unused_tx_miss;
  assign unused_tx_miss = tx_miss;

  always_comb begin
    status_o              = '0;
    status_o[ST_BUSY]     = engine_busy_i | ~tx_empty;
    status_o[ST_TX_FULL]  = tx_full;
    status_o[ST_TX_EMPTY] = tx_empty;
    status_o[ST_RX_EMPTY] = rx_empty;
    status_o[ST_RX_FULL]  = rx_full;
  end

  assign tx_dma_req_o = dma_en_o[DMA_TX_EN] && (tx_level_o <= LW'(tx_dma_lvl_o));
  assign rx_dma_req_o = dma_en_o[DMA_RX_EN] && (rx_level_o >  LW'(rx_dma_lvl_o));

  a_r3_tx_full_empty_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[ST_TX_FULL] && status_o[ST_TX_EMPTY]));

  a_r10_tx_req_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_req_o |-> dma_en_o[DMA_TX_EN]);

  a_r10_rx_req_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_req_o |-> (dma_en_o[DMA_RX_EN] && !status_o[ST_RX_EMPTY]));

  a_r11_busy_with_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[ST_TX_EMPTY] |-> status_o[ST_BUSY]);
endmodule

// File: tb/fifo_irq_dma_ctrl_tb_top.sv
module fifo_irq_dma_ctrl_tb_top;
  localparam int DEPTH = 8;
  localparam int DW    = 16;
  localparam int CW    = 8;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int TW    = $clog2(DEPTH);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tx_push_i = 1'b0, tx_pop_i = 1'b0, rx_push_i = 1'b0, rx_pop_i = 1'b0;
  logic [DW-1:0] tx_wdata_i = '0, rx_wdata_i = '0;
  logic          engine_busy_i = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [2:0]    cfg_sel_i = '0;
  logic [CW-1:0] cfg_wdata_i = '0;
  logic [DW-1:0] tx_rdata_o, rx_rdata_o;
  logic [LW-1:0] tx_level_o, rx_level_o;
  logic [4:0]    status_o, raw_irq_o, masked_irq_o, irq_mask_o;
  logic          irq_o, tx_dma_req_o, rx_dma_req_o;
  logic [TW-1:0] tx_irq_thr_o, rx_irq_thr_o, tx_dma_lvl_o, rx_dma_lvl_o;
  logic [1:0]    dma_en_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] tx_q[$];
  logic [DW-1:0] rx_q[$];
  logic [DW-1:0] tx_exp, rx_exp;

  always #4 clk_i = ~clk_i;

  fifo_irq_dma_ctrl #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) dut_i (
    .clk_i, .rst_ni,
    .tx_push_i, .tx_wdata_i, .tx_pop_i, .tx_rdata_o,
    .rx_push_i, .rx_wdata_i, .rx_pop_i, .rx_rdata_o,
    .engine_busy_i, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i,
    .tx_level_o, .rx_level_o, .status_o, .raw_irq_o, .masked_irq_o, .irq_o,
    .tx_irq_thr_o, .rx_irq_thr_o, .tx_dma_lvl_o, .rx_dma_lvl_o,
    .irq_mask_o, .dma_en_o, .tx_dma_req_o, .rx_dma_req_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  // drivers: expected words enter the scoreboard queues here
  task automatic push_tx(input logic [DW-1:0] d);
    tx_push_i = 1'b1; tx_wdata_i = d;
    if (tx_q.size() < DEPTH) tx_q.push_back(d);
    tick();
    tx_push_i = 1'b0;
  endtask

  task automatic push_rx(input logic [DW-1:0] d);
    rx_push_i = 1'b1; rx_wdata_i = d;
    if (rx_q.size() < DEPTH) rx_q.push_back(d);
    tick();
    rx_push_i = 1'b0;
  endtask

  task automatic pop_tx();
    tx_pop_i = 1'b1; tick(); tx_pop_i = 1'b0;
  endtask

  task automatic pop_rx();
    rx_pop_i = 1'b1; tick(); rx_pop_i = 1'b0;
  endtask

  task automatic cfg_wr(input logic [2:0] sel, input logic [CW-1:0] d);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    tick();
    cfg_we_i = 1'b0;
  endtask

  // monitor: compares every popped word with the scoreboard, mid-cycle
  always @(negedge clk_i) begin
    if (rst_ni && tx_pop_i) begin
      tx_exp = '0;
      if (tx_q.size() > 0) tx_exp = tx_q.pop_front();
      check("R2 tx order", 32'(tx_rdata_o), 32'(tx_exp));
    end
    if (rst_ni && rx_pop_i) begin
      rx_exp = '0;
      if (rx_q.size() > 0) rx_exp = rx_q.pop_front();
      check("R2 R5 rx order", 32'(rx_rdata_o), 32'(rx_exp));
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    // R1 reset state
    check("R1 tx level", 32'(tx_level_o), 0);
    check("R1 rx level", 32'(rx_level_o), 0);
    check("R1 status", 32'(status_o), 32'h0C);
    check("R1 raw", 32'(raw_irq_o), 32'h01);
    check("R1 irq", 32'(irq_o), 0);
    check("R1 dma reqs", 32'({tx_dma_req_o, rx_dma_req_o}), 0);
    check("R1 regs", 32'({tx_irq_thr_o, rx_irq_thr_o, irq_mask_o, dma_en_o}), 0);

    // R6 depth discovery through watermark readback
    cfg_wr(3'd0, 8'd8);   check("R6 reject depth", 32'(tx_irq_thr_o), 0);
    cfg_wr(3'd0, 8'd7);   check("R6 accept depth-1", 32'(tx_irq_thr_o), 7);
    cfg_wr(3'd0, 8'd200); check("R6 reject large", 32'(tx_irq_thr_o), 7);
    cfg_wr(3'd0, 8'd3);
    cfg_wr(3'd1, 8'd3);   check("R6 rx thr", 32'(rx_irq_thr_o), 3);
    // R12 unused select
    cfg_wr(3'd7, 8'h55);
    check("R12 no mask change", 32'(irq_mask_o), 0);
    check("R12 no dma change", 32'(dma_en_o), 0);
    check("R12 no thr change", 32'(tx_irq_thr_o), 3);

    // R2 R3 R7 R11 transmit fill
    for (int i = 0; i < 3; i++) push_tx(16'hA000 + 16'(i));
    check("R2 tx level 3", 32'(tx_level_o), 3);
    check("R7 tx at thr", 32'(raw_irq_o), 32'h01);
    check("R3 R11 status busy", 32'(status_o), 32'h09);
    push_tx(16'hA003);
    check("R7 tx above thr", 32'(raw_irq_o), 32'h00);
    for (int i = 4; i < 8; i++) push_tx(16'hA000 + 16'(i));
    check("R3 tx full", 32'(status_o), 32'h0B);
    push_tx(16'hDEAD);
    check("R4 level kept", 32'(tx_level_o), 8);
    check("R4 overflow raw", 32'(raw_irq_o), 32'h02);
    for (int i = 0; i < 8; i++) pop_tx();
    check("R2 tx drained", 32'(tx_level_o), 0);
    check("R3 idle status", 32'(status_o), 32'h0C);
    pop_tx();
    check("R5 tx miss no flag", 32'(raw_irq_o), 32'h03);

    // receive path
    for (int i = 0; i < 5; i++) push_rx(16'h5000 + 16'(i));
    check("R7 rx above thr", 32'(raw_irq_o), 32'h13);
    check("R3 rx not empty", 32'(status_o), 32'h04);
    for (int i = 0; i < 5; i++) pop_rx();
    check("R2 rx level zero", 32'(rx_level_o), 0);
    pop_rx();
    check("R5 underflow", 32'(raw_irq_o), 32'h07);
    for (int i = 0; i < 9; i++) push_rx(16'h6000 + 16'(i));
    check("R5 rx level kept", 32'(rx_level_o), 8);
    check("R5 overflow raw", 32'(raw_irq_o), 32'h1F);
    check("R3 rx full", 32'(status_o), 32'h14);

    // R8 mask
    cfg_wr(3'd4, 8'h08);
    check("R8 masked", 32'(masked_irq_o), 32'h08);
    check("R8 irq on", 32'(irq_o), 1);
    cfg_wr(3'd4, 8'h00);
    check("R8 irq off", 32'(irq_o), 0);

    // R9 clears
    cfg_wr(3'd6, 8'h04); check("R9 clear rx ovf", 32'(raw_irq_o), 32'h17);
    cfg_wr(3'd6, 8'h02); check("R9 clear rx udf", 32'(raw_irq_o), 32'h13);
    cfg_wr(3'd6, 8'h01); check("R9 clear all", 32'(raw_irq_o), 32'h11);

    // R10 DMA
    cfg_wr(3'd2, 8'd2);
    cfg_wr(3'd3, 8'd4);
    check("R10 disabled", 32'({tx_dma_req_o, rx_dma_req_o}), 0);
    cfg_wr(3'd5, 8'h01);
    check("R10 rx only", 32'({tx_dma_req_o, rx_dma_req_o}), 32'h1);
    cfg_wr(3'd5, 8'h03);
    check("R10 both", 32'({tx_dma_req_o, rx_dma_req_o}), 32'h3);
    for (int i = 0; i < 4; i++) pop_rx();
    check("R10 rx at lvl", 32'(rx_dma_req_o), 0);
    check("R7 rx 4 over 3", 32'(raw_irq_o), 32'h11);
    pop_rx();
    check("R7 rx at thr", 32'(raw_irq_o), 32'h01);

    // R11 engine busy
    engine_busy_i = 1'b1; #1;
    check("R11 engine busy", 32'(status_o), 32'h05);
    engine_busy_i = 1'b0;

    // R9 set wins over clear in the same cycle
    for (int i = 0; i < 3; i++) pop_rx();
    rx_pop_i = 1'b1; cfg_we_i = 1'b1; cfg_sel_i = 3'd6; cfg_wdata_i = 8'h01;
    tick();
    rx_pop_i = 1'b0; cfg_we_i = 1'b0;
    check("R9 set wins", 32'(raw_irq_o), 32'h05);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule